// File: doc/BRIEF.md
# Saturating Multiply and Square-Accumulate Unit

This block is a register-controlled 32-bit arithmetic engine. It covers six operations: a 32-bit signed product, a 32-bit signed square, an unsigned or signed 64-bit product, and two accumulate modes. One accumulate mode adds a signed product to a running 64-bit sum. The other adds the square of operand A to that sum. Software first selects the operation with a function code in the control register and loads operand B. Writing operand A then launches the computation. Results land in a low and a high result word. In the accumulate modes these two words together form the accumulator, so software can preload or zero the accumulator by writing them directly.

The 32-bit and accumulate modes share one saturation enable and one sticky overflow flag. When an overflow goes toward the negative limit, a sticky underflow flag is also raised. Each flag is cleared by writing 1 to its own bit of a clear register. A busy flag in the status word covers the fixed two-cycle latency of every operation.

Top module: `sat_mac`

## Requirements
- R1: The register addresses are: 0 control, 1 operand B, 2 operand A, 3 result low, 4 result high, 5 status (read only), 6 flag clear (write only, reads 0). After reset, every readable register reads 0.
- R2: A write to operand A while the unit is idle starts an operation. Status bit 8 (busy) is then high for exactly two cycles, and the results appear when busy falls. A write to operand A while busy is ignored: the operand is not stored and no operation starts.
- R3: Function code 6 writes the low 32 bits of the signed product A×B to result low. Result high is left unchanged.
- R4: Function code 7 writes the signed square A×A to result low, ignoring operand B. Result high is left unchanged.
- R5: Function code 8 forms the unsigned 64-bit product and code 9 the signed 64-bit product. The low word goes to result low and the high word to result high.
- R6: Code 10 adds the signed product A×B to the 64-bit accumulator {result high, result low}. Code 11 adds A×A to it. Direct writes to the result registers preload the accumulator, and the result registers change only by such writes or by a completing operation.
- R7: In codes 6, 7, 10 and 11, a result that does not fit the signed destination (32 bits, or 64 bits for accumulation) sets sticky status bit 1. With saturation off, the wrapped result is stored.
- R8: With control bit 22 set, an overflowing result in codes 6, 7, 10 and 11 is clamped: to the largest positive value of the destination width, or to the most negative value when the overflow went below range.
- R9: An overflow below the negative limit also sets sticky status bit 0.
- R10: A write to the clear register with bit 1 set clears status bit 1, and with bit 0 set clears status bit 0. The two clears act independently. A flag set in the same cycle as its clear stays set.
- R11: Any other function code still produces the two-cycle busy pulse, but it changes neither the results nor the flags.
- R12: The control register stores only the function code in bits 4:0 and the saturation enable in bit 22. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register write address |
| wr_data | input | W (32) | Register write data |
| rd_addr | input | AW (3) | Register read address |
| rd_data | output | W (32) | Combinational read data for rd_addr |

## Verification
The write to operand A is captured on clock edge T0. Busy reads 1 after T0 and after T1, and it falls together with the update of the results and flags on edge T2. The scoreboard counts falling edges and records each expected item against the falling edge it is due at. It checks busy and the old flags at the first two falling edges after T0. At the third falling edge it checks the result words and the new status. For the ignored second write, a fourth item confirms that the state is unchanged and the unit is idle.

// File: rtl/smac_pkg.sv
package smac_pkg;

    localparam int DW     = 32;
    localparam int ADDR_W = 3;
    localparam int FN_W   = 5;

    // register addresses
    localparam int A_CTRL = 0;
    localparam int A_OPB  = 1;
    localparam int A_OPA  = 2;
    localparam int A_RLO  = 3;
    localparam int A_RHI  = 4;
    localparam int A_STAT = 5;
    localparam int A_CLR  = 6;

    // bit positions that software decodes
    localparam int CTRL_SAT_BIT = 22;
    localparam int ST_BUSY_BIT  = 8;
    localparam int ST_OVF_BIT   = 1;
    localparam int ST_UF_BIT    = 0;
    localparam int CLR_OVF_BIT  = 1;
    localparam int CLR_UF_BIT   = 0;

    // sticky flag vector layout
    localparam int NFLAG  = 2;
    localparam int FL_UF  = 0;
    localparam int FL_OVF = 1;

    typedef enum logic [FN_W-1:0] {
        FN_NOP    = 5'd0,
        FN_MUL32  = 5'd6,
        FN_SQR32  = 5'd7,
        FN_MULU64 = 5'd8,
        FN_MULS64 = 5'd9,
        FN_MAC    = 5'd10,
        FN_SAC    = 5'd11
    } fn_e;

    typedef struct packed {
        logic [FN_W-1:0] fn;
        logic            sat;
    } job_t;

    function automatic logic fn_squares(input logic [FN_W-1:0] f);
        return (f == FN_SQR32) || (f == FN_SAC);
    endfunction

    function automatic logic fn_signed(input logic [FN_W-1:0] f);
        return f != FN_MULU64;
    endfunction

    function automatic logic fn_is32(input logic [FN_W-1:0] f);
        return (f == FN_MUL32) || (f == FN_SQR32);
    endfunction

endpackage

// File: rtl/smac_mult.sv
module smac_mult
    import smac_pkg::*;
#(
    parameter int W = DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sgn,
    input  job_t           job_in,
    output logic           out_valid,
    output logic [2*W-1:0] prod,
    output job_t           job_out
);
    localparam int PW = 2 * W;

    logic [PW-1:0] ea;
    logic [PW-1:0] eb;

    // one multiplier serves signed and unsigned: extend by sign or by zero
    assign ea = {{W{sgn & a[W-1]}}, a};
    assign eb = {{W{sgn & b[W-1]}}, b};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            prod      <= '0;
            job_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                prod    <= ea * eb;
                job_out <= job_in;
            end
        end
    end

endmodule

// File: rtl/smac_post.sv
module smac_post
    import smac_pkg::*;
#(
    parameter int W = DW
) (
    input  job_t           job,
    input  logic [2*W-1:0] prod,
    input  logic [W-1:0]   acc_lo,
    input  logic [W-1:0]   acc_hi,
    output logic [W-1:0]   new_lo,
    output logic [W-1:0]   new_hi,
    output logic           wr_lo,
    output logic           wr_hi,
    output logic           ovf,
    output logic           neg
);
    localparam int PW = 2 * W;
    localparam logic [W-1:0]  MAXW = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0]  MINW = {1'b1, {(W-1){1'b0}}};
    localparam logic [PW-1:0] MAXP = {1'b0, {(PW-1){1'b1}}};
    localparam logic [PW-1:0] MINP = {1'b1, {(PW-1){1'b0}}};

    logic [PW-1:0] acc;
    logic [PW-1:0] sum;

    assign acc = {acc_hi, acc_lo};
    assign sum = acc + prod;

    always_comb begin
        new_lo = acc_lo;
        new_hi = acc_hi;
        wr_lo  = 1'b0;
        wr_hi  = 1'b0;
        ovf    = 1'b0;
        neg    = 1'b0;
        case (job.fn)
            FN_MUL32, FN_SQR32: begin
                // fits in W signed bits when the top W+1 bits agree
                wr_lo  = 1'b1;
                neg    = prod[PW-1];
                ovf    = !((&prod[PW-1:W-1]) || !(|prod[PW-1:W-1]));
                new_lo = (ovf && job.sat) ? (neg ? MINW : MAXW) : prod[W-1:0];
            end
            FN_MULU64, FN_MULS64: begin
                wr_lo  = 1'b1;
                wr_hi  = 1'b1;
                new_lo = prod[W-1:0];
                new_hi = prod[PW-1:W];
            end
            FN_MAC, FN_SAC: begin
                wr_lo = 1'b1;
                wr_hi = 1'b1;
                neg   = acc[PW-1];
                ovf   = (acc[PW-1] == prod[PW-1]) && (sum[PW-1] != acc[PW-1]);
                {new_hi, new_lo} = (ovf && job.sat) ? (neg ? MINP : MAXP) : sum;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/smac_flags.sv
module smac_flags
    import smac_pkg::*;
#(
    parameter int N = NFLAG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (set[i])
                q[i] <= 1'b1;
            else if (clr[i])
                q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/sat_mac.sv
module sat_mac
    import smac_pkg::*;
#(
    parameter int W  = DW,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    localparam int PW = 2 * W;

    // write decode
    logic w_ctrl, w_opb, w_opa, w_rlo, w_rhi, w_clr;
    assign w_ctrl = wr_en && (wr_addr == AW'(A_CTRL));
    assign w_opb  = wr_en && (wr_addr == AW'(A_OPB));
    assign w_opa  = wr_en && (wr_addr == AW'(A_OPA));
    assign w_rlo  = wr_en && (wr_addr == AW'(A_RLO));
    assign w_rhi  = wr_en && (wr_addr == AW'(A_RHI));
    assign w_clr  = wr_en && (wr_addr == AW'(A_CLR));

    // software-visible state
    logic [FN_W-1:0] ctrl_fn;
    logic            ctrl_sat;
    logic [W-1:0]    opb_q;
    logic [W-1:0]    opa_q;
    logic [W-1:0]    res_lo_q;
    logic [W-1:0]    res_hi_q;

    // pipeline
    logic            s1_valid;
    logic [W-1:0]    s1_a;
    logic [W-1:0]    s1_b;
    logic            s1_sgn;
    job_t            s1_job;
    logic            s2_valid;
    logic [PW-1:0]   s2_prod;
    job_t            s2_job;

    logic            busy_w;
    logic            start_w;

    assign busy_w  = s1_valid | s2_valid;
    assign start_w = w_opa & ~busy_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_fn  <= '0;
            ctrl_sat <= 1'b0;
            opb_q    <= '0;
            opa_q    <= '0;
            s1_valid <= 1'b0;
            s1_a     <= '0;
            s1_b     <= '0;
            s1_sgn   <= 1'b0;
            s1_job   <= '0;
        end else begin
            if (w_ctrl) begin
                ctrl_fn  <= wr_data[FN_W-1:0];
                ctrl_sat <= wr_data[CTRL_SAT_BIT];
            end
            if (w_opb)
                opb_q <= wr_data;
            if (start_w)
                opa_q <= wr_data;
            s1_valid <= start_w;
            if (start_w) begin
                s1_a   <= wr_data;
                s1_b   <= fn_squares(ctrl_fn) ? wr_data : opb_q;
                s1_sgn <= fn_signed(ctrl_fn);
                s1_job <= '{fn: ctrl_fn, sat: ctrl_sat};
            end
        end
    end

    smac_mult #(.W(W)) u_mult (
        .clk      (clk),
        .rst      (rst),
        .in_valid (s1_valid),
        .a        (s1_a),
        .b        (s1_b),
        .sgn      (s1_sgn),
        .job_in   (s1_job),
        .out_valid(s2_valid),
        .prod     (s2_prod),
        .job_out  (s2_job)
    );

    // writeback
    logic [W-1:0] wb_lo;
    logic [W-1:0] wb_hi;
    logic         wb_wr_lo;
    logic         wb_wr_hi;
    logic         wb_ovf;
    logic         wb_neg;
    logic         wb_fire;
    logic         wb_sat;
    logic         wb_is32;
    logic         wr_res;

    smac_post #(.W(W)) u_post (
        .job   (s2_job),
        .prod  (s2_prod),
        .acc_lo(res_lo_q),
        .acc_hi(res_hi_q),
        .new_lo(wb_lo),
        .new_hi(wb_hi),
        .wr_lo (wb_wr_lo),
        .wr_hi (wb_wr_hi),
        .ovf   (wb_ovf),
        .neg   (wb_neg)
    );

    assign wb_fire = s2_valid;
    assign wb_sat  = s2_job.sat;
    assign wb_is32 = fn_is32(s2_job.fn);
    assign wr_res  = w_rlo | w_rhi;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_lo_q <= '0;
            res_hi_q <= '0;
        end else begin
            if (wb_fire && wb_wr_lo)
                res_lo_q <= wb_lo;
            else if (w_rlo)
                res_lo_q <= wr_data;
            if (wb_fire && wb_wr_hi)
                res_hi_q <= wb_hi;
            else if (w_rhi)
                res_hi_q <= wr_data;
        end
    end

    // sticky flags
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    logic [NFLAG-1:0] flag_q;
    logic             ovf_q;
    logic             uf_q;
    logic             clr_ovf;
    logic             clr_uf;

    assign clr_ovf = w_clr & wr_data[CLR_OVF_BIT];
    assign clr_uf  = w_clr & wr_data[CLR_UF_BIT];

    always_comb begin
        flag_set         = '0;
        flag_clr         = '0;
        flag_set[FL_OVF] = wb_fire & wb_ovf;
        flag_set[FL_UF]  = wb_fire & wb_ovf & wb_neg;
        flag_clr[FL_OVF] = clr_ovf;
        flag_clr[FL_UF]  = clr_uf;
    end

    smac_flags #(.N(NFLAG)) u_flags (
        .clk(clk),
        .rst(rst),
        .set(flag_set),
        .clr(flag_clr),
        .q  (flag_q)
    );

    assign ovf_q = flag_q[FL_OVF];
    assign uf_q  = flag_q[FL_UF];

    // read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            AW'(A_CTRL): begin
                rd_data[FN_W-1:0]    = ctrl_fn;
                rd_data[CTRL_SAT_BIT] = ctrl_sat;
            end
            AW'(A_OPB):  rd_data = opb_q;
            AW'(A_OPA):  rd_data = opa_q;
            AW'(A_RLO):  rd_data = res_lo_q;
            AW'(A_RHI):  rd_data = res_hi_q;
            AW'(A_STAT): begin
                rd_data[ST_BUSY_BIT] = busy_w;
                rd_data[ST_OVF_BIT]  = ovf_q;
                rd_data[ST_UF_BIT]   = uf_q;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/smac_chk.sv
module smac_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         wb_fire,
    input logic         wb_ovf,
    input logic         wb_neg,
    input logic         wb_sat,
    input logic         wb_is32,
    input logic         wr_res,
    input logic         clr_ovf,
    input logic         ovf_q,
    input logic         uf_q,
    input logic [W-1:0] res_lo,
    input logic [W-1:0] res_hi
);
    localparam logic [W-1:0] MAXW = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINW = {1'b1, {(W-1){1'b0}}};

    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    a_r2_busy_len: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy ##1 !busy);

    a_r2_wb_idle: assert property (@(posedge clk) disable iff (rst)
        wb_fire |=> !busy);

    a_r6_res_hold: assert property (@(posedge clk) disable iff (rst)
        (!wb_fire && !wr_res) |=> ($stable(res_lo) && $stable(res_hi)));

    a_r7_ovf_set: assert property (@(posedge clk) disable iff (rst)
        (wb_fire && wb_ovf) |=> ovf_q);

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clr_ovf) |=> ovf_q);

    a_r8_sat32: assert property (@(posedge clk) disable iff (rst)
        (wb_fire && wb_ovf && wb_sat && wb_is32) |=> (res_lo == MAXW || res_lo == MINW));

    a_r9_uf_set: assert property (@(posedge clk) disable iff (rst)
        (wb_fire && wb_ovf && wb_neg) |=> uf_q);

    a_r10_clr_ovf: assert property (@(posedge clk) disable iff (rst)
        (clr_ovf && !(wb_fire && wb_ovf)) |=> !ovf_q);

endmodule

bind sat_mac smac_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start_w),
    .busy   (busy_w),
    .wb_fire(wb_fire),
    .wb_ovf (wb_ovf),
    .wb_neg (wb_neg),
    .wb_sat (wb_sat),
    .wb_is32(wb_is32),
    .wr_res (wr_res),
    .clr_ovf(clr_ovf),
    .ovf_q  (ovf_q),
    .uf_q   (uf_q),
    .res_lo (res_lo_q),
    .res_hi (res_hi_q)
);

// File: tb/sim_sat_mac.sv
module sim_sat_mac;
    import smac_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  drv_addr;
    logic [2:0]  mon_addr;
    logic        mon_own;
    wire  [2:0]  rd_addr = mon_own ? mon_addr : drv_addr;
    logic [31:0] rd_data;

    sat_mac u0 (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    typedef struct {
        int          due;
        bit          full;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] st;
        string       tag;
    } item_t;

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic        of;
        logic        uf;
    } mres_t;

    item_t sbq[$];
    int    checks = 0;
    int    errors = 0;
    int    ncyc   = 0;
    mres_t m;

    function automatic logic [31:0] st_word(input logic busy, input logic of, input logic uf);
        return {23'b0, busy, 6'b0, of, uf};
    endfunction

    // reference model written from the requirements
    function automatic mres_t model(input logic [4:0] fn, input logic sat,
                                    input logic [31:0] a, input logic [31:0] b,
                                    input mres_t cur);
        mres_t              r;
        longint             p;
        logic [63:0]        pu;
        logic signed [65:0] s;
        logic [31:0]        bb;
        r  = cur;
        bb = (fn == 5'd7 || fn == 5'd11) ? a : b;
        p  = longint'($signed(a)) * longint'($signed(bb));
        case (fn)
            5'd6, 5'd7: begin
                if (p > 64'sd2147483647) begin
                    r.of = 1'b1;
                    r.lo = sat ? 32'h7FFF_FFFF : p[31:0];
                end else if (p < -64'sd2147483648) begin
                    r.of = 1'b1;
                    r.uf = 1'b1;
                    r.lo = sat ? 32'h8000_0000 : p[31:0];
                end else begin
                    r.lo = p[31:0];
                end
            end
            5'd8: begin
                pu   = {32'b0, a} * {32'b0, b};
                r.lo = pu[31:0];
                r.hi = pu[63:32];
            end
            5'd9: begin
                r.lo = p[31:0];
                r.hi = p[63:32];
            end
            5'd10, 5'd11: begin
                s = $signed({{2{cur.hi[31]}}, cur.hi, cur.lo}) + $signed({{2{p[63]}}, p});
                if (s > 66'sh0_7FFF_FFFF_FFFF_FFFF) begin
                    r.of = 1'b1;
                    {r.hi, r.lo} = sat ? 64'h7FFF_FFFF_FFFF_FFFF : s[63:0];
                end else if (s < -66'sh0_8000_0000_0000_0000) begin
                    r.of = 1'b1;
                    r.uf = 1'b1;
                    {r.hi, r.lo} = sat ? 64'h8000_0000_0000_0000 : s[63:0];
                end else begin
                    {r.hi, r.lo} = s[63:0];
                end
            end
            default: ;
        endcase
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        drv_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic preload(input logic [31:0] hi, input logic [31:0] lo);
        wr(3'(A_RHI), hi);
        wr(3'(A_RLO), lo);
        m.hi = hi;
        m.lo = lo;
    endtask

    task automatic clear(input string tag, input logic [31:0] d);
        logic [31:0] v;
        wr(3'(A_CLR), d);
        if (d[1]) m.of = 1'b0;
        if (d[0]) m.uf = 1'b0;
        rd(3'(A_STAT), v);
        chk(tag, v, st_word(1'b0, m.of, m.uf));
    endtask

    // driver: launches one operation and pushes what is due at each falling edge
    task automatic issue(input string tag, input logic [4:0] fn, input logic sat,
                         input logic [31:0] b, input logic [31:0] a,
                         input bit poke, input logic [31:0] pv);
        item_t it;
        int    k;
        wr(3'(A_CTRL), {9'b0, sat, 17'b0, fn});
        wr(3'(A_OPB), b);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(A_OPA);
        wr_data = a;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        k = ncyc;
        it.full = 1'b0; it.lo = '0; it.hi = '0;
        it.st  = st_word(1'b1, m.of, m.uf);
        it.tag = {tag, " busy1"}; it.due = k + 1; sbq.push_back(it);
        it.tag = {tag, " busy2"}; it.due = k + 2; sbq.push_back(it);
        m = model(fn, sat, a, b, m);
        it.full = 1'b1; it.lo = m.lo; it.hi = m.hi;
        it.st  = st_word(1'b0, m.of, m.uf);
        it.tag = {tag, " result"}; it.due = k + 3; sbq.push_back(it);
        if (poke) begin
            it.tag = {tag, " after ignored start"}; it.due = k + 4; sbq.push_back(it);
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = 3'(A_OPA);
            wr_data = pv;
            @(posedge clk);
            #1;
            wr_en = 1'b0;
        end
        wait (sbq.size() == 0);
    endtask

    // monitor: compares at the falling edge each item is due
    initial begin
        item_t it;
        mon_own  = 1'b0;
        mon_addr = '0;
        forever begin
            @(negedge clk);
            #1;
            ncyc++;
            if (sbq.size() != 0 && sbq[0].due == ncyc) begin
                it       = sbq[0];
                mon_own  = 1'b1;
                mon_addr = 3'(A_STAT);
                #1;
                chk({it.tag, " status"}, rd_data, it.st);
                if (it.full) begin
                    mon_addr = 3'(A_RLO);
                    #1;
                    chk({it.tag, " lo"}, rd_data, it.lo);
                    mon_addr = 3'(A_RHI);
                    #1;
                    chk({it.tag, " hi"}, rd_data, it.hi);
                end
                mon_own = 1'b0;
                void'(sbq.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; drv_addr = '0;
        m = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;

        // R1: reset values
        for (int i = 0; i < 7; i++) begin
            rd(3'(i), v);
            chk($sformatf("R1 reset addr %0d", i), v, 32'h0);
        end

        // R12: control readback masks unused bits
        wr(3'(A_CTRL), 32'hFFFF_FFFF);
        rd(3'(A_CTRL), v);
        chk("R12 ctrl readback", v, 32'h0040_001F);

        // R3: 32-bit signed product, high word untouched
        preload(32'hA5A5_A5A5, 32'h0);
        issue("R3 mul 7*-3", 5'd6, 1'b0, 32'hFFFF_FFFD, 32'd7, 1'b0, '0);

        // R7: overflow without saturation wraps
        issue("R7 mul wrap", 5'd6, 1'b0, 32'h0001_0000, 32'h0001_0000, 1'b0, '0);
        clear("R10 clear ovf", 32'h2);

        // R8: positive clamp
        issue("R8 mul sat pos", 5'd6, 1'b1, 32'h0004_0000, 32'h0004_0000, 1'b0, '0);
        // R8 R9: negative clamp and underflow
        issue("R9 mul sat neg", 5'd6, 1'b1, 32'h0001_0000, 32'hFFFF_0000, 1'b0, '0);
        clear("R10 clear uf only", 32'h1);
        clear("R10 clear ovf only", 32'h2);

        // R4: square ignores operand B
        issue("R4 sqr -5", 5'd7, 1'b0, 32'd999, 32'hFFFF_FFFB, 1'b0, '0);
        issue("R4 sqr sat", 5'd7, 1'b1, 32'd3, 32'h0001_0000, 1'b0, '0);
        clear("R10 clear both", 32'h3);

        // R5: 64-bit products
        issue("R5 mulu64", 5'd8, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, '0);
        issue("R5 muls64", 5'd9, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, '0);

        // R6: accumulation across operations
        preload(32'h0, 32'h0);
        issue("R6 mac 3*4", 5'd10, 1'b0, 32'd4, 32'd3, 1'b0, '0);
        issue("R6 mac -2*5", 5'd10, 1'b0, 32'd5, 32'hFFFF_FFFE, 1'b0, '0);
        issue("R6 sac 16^2", 5'd11, 1'b0, 32'd7, 32'h10, 1'b0, '0);

        // R8: accumulate clamps at the positive 64-bit limit
        preload(32'h7FFF_FFFF, 32'hFFFF_FFF0);
        issue("R8 sac sat", 5'd11, 1'b1, 32'd0, 32'h10, 1'b0, '0);
        clear("R10 clear after sac", 32'h3);
        // R7: same without saturation wraps
        preload(32'h7FFF_FFFF, 32'hFFFF_FFF0);
        issue("R7 sac wrap", 5'd11, 1'b0, 32'd0, 32'h10, 1'b0, '0);
        clear("R10 clear after wrap", 32'h3);

        // R9: accumulate below the negative limit
        preload(32'h8000_0000, 32'h5);
        issue("R9 mac sat neg", 5'd10, 1'b1, 32'h100, 32'hFFFF_FFFF, 1'b0, '0);
        clear("R10 clear after neg", 32'h3);

        // R11: unsupported code leaves everything alone
        preload(32'h1234_5678, 32'h9ABC_DEF0);
        issue("R11 nop code", 5'd0, 1'b1, 32'h7, 32'h7B, 1'b0, '0);
        issue("R11 code 3", 5'd3, 1'b0, 32'h7, 32'h7B, 1'b0, '0);

        // R2: start while busy is ignored
        issue("R2 ignored start", 5'd6, 1'b0, 32'd6, 32'd5, 1'b1, 32'd100);
        rd(3'(A_OPA), v);
        chk("R2 operand A kept", v, 32'd5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule